// File: doc/BRIEF.md
# Per-Processor Local Register Window

Each processor in a cluster owns a small private bank of interrupt-routing registers: a control word, a local pending word, a local mask, a compare-route word, a remote-bank selector, an identity word and a 32-bit compare value. All banks sit behind one shared register port. Every access carries the index of the processor that issued it on a sideband input.

Two windows are decoded. The own-bank window always lands in the issuing processor's bank. The remote window lands in the bank named by the issuing processor's remote-bank selector. This lets one processor program another processor's compare routing, mask and compare value.

The per-bank compare value, the routed pin and a compare-interrupt level leave the block for the neighbouring timer and pin-combining logic. A per-bank timer-expiry pulse comes back in and sets the compare pending flag.

Top module: `lrw_top`

## Requirements
- R1: With `reqOther`=0 an access targets bank `reqCpu`. With `reqOther`=1 it targets the bank held in the remote-bank selector of bank `reqCpu`. A write at offset 6 sets the selector of the targeted bank.
- R2: A write to the remote-bank selector (word offset 6) whose 32-bit value is NUM_CPU or more leaves the selector unchanged. Reads at offset 6 return the selector.
- R3: Offset 2 reads the 6-bit mask, and writes to offset 2 do nothing. A write at offset 4 ORs data[5:0] into the mask. A write at offset 3 clears the mask bits set in data[5:0]. Data bits 31:6 have no effect.
- R4: Offset 7 reads the index of the targeted bank. Offset 8 reads and writes the compare value. Offset 9 always reads 0.
- R5: Offset 0 (control) reads 0, and writes to it change nothing.
- R6: A write to offset 5 whose data[5:0] exceeds MAX_PIN (5) is dropped. Any other write stores only bit 31 (route enable) and bits 5:0 (pin). Reads return the stored word.
- R7: After reset, every bank reads as follows: control 0, pending 0, mask 0x32, route 0x80000000, selector 0, compare 0xFFFFFFFF.
- R8: Offsets 1 and 10–15 ignore writes. Offsets 3, 4 and 10–15 read 0. Offset 1 reads the compare pending flag in bit 1.
- R9: A `timerExpire[b]` pulse sets bank b's pending flag. A compare-value write to bank b clears it. When both happen in the same cycle, the flag ends up set.
- R10: `cmpIrq[b]` equals pending & mask bit 1 & route enable. `cmpPinFlat` carries each bank's pin field and `cmpValueFlat` each bank's compare value.
- R11: An access whose `reqCpu` is NUM_CPU or more changes no state and returns 0 with `rspValid` low.
- R12: `rspValid` rises exactly one cycle after each accepted read, and `rspData` holds the read word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOther | input | 1 | 0 = own-bank window, 1 = remote window |
| reqOfs | input | 4 | Word offset inside the window |
| reqCpu | input | CPU_W | Index of the issuing processor |
| reqWdata | input | 32 | Write data |
| timerExpire | input | NUM_CPU | Per-bank compare expiry pulse |
| rspValid | output | 1 | Read response strobe |
| rspData | output | 32 | Read response data |
| cmpValueFlat | output | NUM_CPU*32 | Compare value of each bank |
| cmpPinFlat | output | NUM_CPU*6 | Routed pin of each bank |
| cmpIrq | output | NUM_CPU | Compare interrupt level per bank |

## Verification
The bench sweeps every offset of both windows for every requester index, including one index past the last processor. It does this after each phase, so a remote window that resolves through the wrong bank's selector, or that writes the selector into the requester's bank instead of the target's, shows up as a wrong identity or mask word. It walks every selector value up to two past the limit and every pin code up to two past the highest pin, where an off-by-one in either bound would store a value that should be dropped. It also lands an expiry pulse in the same cycle as a compare write, where the wrong priority clears a pending interrupt that should stay set.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  localparam int DATA_W  = 32;
  localparam int OFS_W   = 4;
  localparam int CMP_BIT = 1;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_PEND  = 4'd1;
  localparam logic [OFS_W-1:0] OFS_MASK  = 4'd2;
  localparam logic [OFS_W-1:0] OFS_MCLR  = 4'd3;
  localparam logic [OFS_W-1:0] OFS_MSET  = 4'd4;
  localparam logic [OFS_W-1:0] OFS_ROUTE = 4'd5;
  localparam logic [OFS_W-1:0] OFS_OSEL  = 4'd6;
  localparam logic [OFS_W-1:0] OFS_IDENT = 4'd7;
  localparam logic [OFS_W-1:0] OFS_CMPLO = 4'd8;
  localparam logic [OFS_W-1:0] OFS_CMPHI = 4'd9;

  // strobes from the decoder to the register banks
  typedef struct packed {
    logic rd;
    logic wrSet;
    logic wrClr;
    logic wrRoute;
    logic wrOsel;
    logic wrCmp;
  } lrwStrobe_t;
endpackage

// File: rtl/lrw_ctrl.sv
module lrw_ctrl
  import lrw_pkg::*;
#(
  parameter int NUM_CPU = 3,
  parameter int CPU_W   = 2,
  parameter int PIN_W   = 6,
  parameter int MAX_PIN = 5
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqOther,
  input  logic [OFS_W-1:0]  reqOfs,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CPU_W-1:0]  otherSel [NUM_CPU],
  output lrwStrobe_t        strobe,
  output logic [CPU_W-1:0]  target,
  output logic [OFS_W-1:0]  accOfs
);
  localparam logic [CPU_W:0]    CPU_LIM  = (CPU_W+1)'(NUM_CPU);
  localparam logic [PIN_W-1:0]  PIN_LIM  = PIN_W'(MAX_PIN);
  localparam logic [DATA_W-1:0] OSEL_LIM = DATA_W'(NUM_CPU);

  logic             reqOk;
  logic             isWr;
  logic             pinOk;
  logic             oselOk;
  logic [CPU_W-1:0] ownIdx;

  always_comb begin
    reqOk  = reqValid && ({1'b0, reqCpu} < CPU_LIM);
    ownIdx = reqOk ? reqCpu : '0;
    target = reqOther ? otherSel[ownIdx] : ownIdx;
    accOfs = reqOfs;
    isWr   = reqOk && reqWrite;
    pinOk  = reqWdata[PIN_W-1:0] <= PIN_LIM;
    oselOk = reqWdata < OSEL_LIM;

    strobe.rd      = reqOk && !reqWrite;
    strobe.wrSet   = isWr && (reqOfs == OFS_MSET);
    strobe.wrClr   = isWr && (reqOfs == OFS_MCLR);
    strobe.wrRoute = isWr && (reqOfs == OFS_ROUTE) && pinOk;
    strobe.wrOsel  = isWr && (reqOfs == OFS_OSEL) && oselOk;
    strobe.wrCmp   = isWr && (reqOfs == OFS_CMPLO);
  end
endmodule

// File: rtl/lrw_regs.sv
module lrw_regs
  import lrw_pkg::*;
#(
  parameter int NUM_CPU  = 3,
  parameter int CPU_W    = 2,
  parameter int PIN_W    = 6,
  parameter int MASK_W   = 6,
  parameter int MASK_RST = 'h32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrwStrobe_t        strobe,
  input  logic [CPU_W-1:0]  target,
  input  logic [OFS_W-1:0]  accOfs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CPU-1:0] timerExpire,
  output logic [CPU_W-1:0]  otherSel [NUM_CPU],
  output logic [NUM_CPU-1:0] pendVec,
  output logic [NUM_CPU-1:0] maskCmp,
  output logic [NUM_CPU-1:0] routeEn,
  output logic [PIN_W-1:0]  routePin [NUM_CPU],
  output logic [DATA_W-1:0] cmpVal [NUM_CPU],
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam logic [MASK_W-1:0] MASK_INIT = MASK_W'(MASK_RST);

  logic [MASK_W-1:0] maskR [NUM_CPU];
  logic              pendR [NUM_CPU];
  logic [DATA_W-1:0] rdWord;

  for (genvar b = 0; b < NUM_CPU; b++) begin : g_bank
    localparam logic [CPU_W-1:0] BIDX = CPU_W'(b);
    logic hit;
    assign hit = (target == BIDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskR[b]    <= MASK_INIT;
        pendR[b]    <= 1'b0;
        routeEn[b]  <= 1'b1;
        routePin[b] <= '0;
        otherSel[b] <= '0;
        cmpVal[b]   <= '1;
      end else begin
        if (strobe.wrSet && hit)
          maskR[b] <= maskR[b] | wdata[MASK_W-1:0];
        else if (strobe.wrClr && hit)
          maskR[b] <= maskR[b] & ~wdata[MASK_W-1:0];
        if (strobe.wrRoute && hit) begin
          routeEn[b]  <= wdata[DATA_W-1];
          routePin[b] <= wdata[PIN_W-1:0];
        end
        if (strobe.wrOsel && hit)
          otherSel[b] <= wdata[CPU_W-1:0];
        if (strobe.wrCmp && hit)
          cmpVal[b] <= wdata;
        // expiry wins over the clear caused by a compare write
        if (timerExpire[b])
          pendR[b] <= 1'b1;
        else if (strobe.wrCmp && hit)
          pendR[b] <= 1'b0;
      end
    end

    assign pendVec[b] = pendR[b];
    assign maskCmp[b] = maskR[b][CMP_BIT];
  end

  always_comb begin
    rdWord = '0;
    case (accOfs)
      OFS_PEND:  rdWord[CMP_BIT] = pendR[target];
      OFS_MASK:  rdWord[MASK_W-1:0] = maskR[target];
      OFS_ROUTE: begin
        rdWord[DATA_W-1]  = routeEn[target];
        rdWord[PIN_W-1:0] = routePin[target];
      end
      OFS_OSEL:  rdWord[CPU_W-1:0] = otherSel[target];
      OFS_IDENT: rdWord[CPU_W-1:0] = target;
      OFS_CMPLO: rdWord = cmpVal[target];
      default:   rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.rd;
      rspData  <= strobe.rd ? rdWord : '0;
    end
  end
endmodule

// File: rtl/lrw_top.sv
module lrw_top
  import lrw_pkg::*;
#(
  parameter int NUM_CPU = 3,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int PIN_W   = 6,
  parameter int MAX_PIN = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic                      reqOther,
  input  logic [OFS_W-1:0]          reqOfs,
  input  logic [CPU_W-1:0]          reqCpu,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [NUM_CPU-1:0]        timerExpire,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData,
  output logic [NUM_CPU*DATA_W-1:0] cmpValueFlat,
  output logic [NUM_CPU*PIN_W-1:0]  cmpPinFlat,
  output logic [NUM_CPU-1:0]        cmpIrq
);
  lrwStrobe_t          strobe;
  logic [CPU_W-1:0]    target;
  logic [OFS_W-1:0]    accOfs;
  logic [CPU_W-1:0]    otherSel [NUM_CPU];
  logic [NUM_CPU-1:0]  pendVec;
  logic [NUM_CPU-1:0]  maskCmp;
  logic [NUM_CPU-1:0]  routeEn;
  logic [PIN_W-1:0]    routePin [NUM_CPU];
  logic [DATA_W-1:0]   cmpVal [NUM_CPU];
  logic [NUM_CPU*CPU_W-1:0] otherSelFlat;

  lrw_ctrl #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .PIN_W(PIN_W), .MAX_PIN(MAX_PIN)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqOther(reqOther), .reqOfs(reqOfs),
    .reqCpu(reqCpu), .reqWdata(reqWdata), .otherSel(otherSel),
    .strobe(strobe), .target(target), .accOfs(accOfs)
  );

  lrw_regs #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .target(target), .accOfs(accOfs),
    .wdata(reqWdata), .timerExpire(timerExpire), .otherSel(otherSel),
    .pendVec(pendVec), .maskCmp(maskCmp), .routeEn(routeEn), .routePin(routePin),
    .cmpVal(cmpVal), .rspValid(rspValid), .rspData(rspData)
  );

  for (genvar b = 0; b < NUM_CPU; b++) begin : g_out
    assign cmpIrq[b] = pendVec[b] & maskCmp[b] & routeEn[b];
    assign cmpPinFlat[b*PIN_W +: PIN_W]     = routePin[b];
    assign cmpValueFlat[b*DATA_W +: DATA_W] = cmpVal[b];
    assign otherSelFlat[b*CPU_W +: CPU_W]   = otherSel[b];
  end
endmodule

// File: rtl/lrw_checker.sv
module lrw_checker
  import lrw_pkg::*;
#(
  parameter int NUM_CPU = 3,
  parameter int CPU_W   = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqOther,
  input logic [OFS_W-1:0]         reqOfs,
  input logic [CPU_W-1:0]         reqCpu,
  input logic [NUM_CPU-1:0]       timerExpire,
  input logic                     rspValid,
  input logic [DATA_W-1:0]        rspData,
  input logic [NUM_CPU*CPU_W-1:0] otherSelFlat,
  input logic [NUM_CPU-1:0]       pendVec,
  input lrwStrobe_t               strobe,
  input logic [CPU_W-1:0]         target
);
  localparam logic [CPU_W:0] CPU_LIM = (CPU_W+1)'(NUM_CPU);

  assert_resp_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd |=> rspValid);
  assert_no_resp_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rd |=> !rspValid);
  assert_ctrl_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && reqOfs == OFS_CTRL) |=> (rspData == '0));
  assert_ident_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && reqOfs == OFS_IDENT) |=> (rspData == DATA_W'($past(target))));
  assert_own_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && !reqOther && reqOfs == OFS_IDENT) |=> (rspData == DATA_W'($past(reqCpu))));
  assert_cmphi_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && reqOfs == OFS_CMPHI) |=> (rspData == '0));

  for (genvar b = 0; b < NUM_CPU; b++) begin : g_chk
    assert_osel_range_R2: assert property (@(posedge clk) disable iff (!rstN)
      ({1'b0, otherSelFlat[b*CPU_W +: CPU_W]} < CPU_LIM));
    assert_expire_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
      timerExpire[b] |=> pendVec[b]);
    assert_cmp_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrCmp && target == CPU_W'(b) && !timerExpire[b]) |=> !pendVec[b]);
  end
endmodule

bind lrw_top lrw_checker #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqOther(reqOther), .reqOfs(reqOfs), .reqCpu(reqCpu),
  .timerExpire(timerExpire), .rspValid(rspValid), .rspData(rspData),
  .otherSelFlat(otherSelFlat), .pendVec(pendVec), .strobe(strobe), .target(target)
);

// File: tb/lrw_top_tb.sv
`timescale 1ns/1ps
module lrw_top_tb;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqOther;
  logic [3:0]  reqOfs;
  logic [1:0]  reqCpu;
  logic [31:0] reqWdata;
  logic [2:0]  timerExpire;
  logic        rspValid;
  logic [31:0] rspData;
  logic [95:0] cmpValueFlat;
  logic [17:0] cmpPinFlat;
  logic [2:0]  cmpIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] lastRd;
  logic        lastVld;

  int          mOsel  [NCPU];
  logic [5:0]  mMask  [NCPU];
  logic [31:0] mRoute [NCPU];
  logic [31:0] mCmp   [NCPU];
  bit          mPend  [NCPU];

  always #2 clk = ~clk;

  lrw_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqOther(reqOther),
    .reqOfs(reqOfs), .reqCpu(reqCpu), .reqWdata(reqWdata), .timerExpire(timerExpire),
    .rspValid(rspValid), .rspData(rspData), .cmpValueFlat(cmpValueFlat),
    .cmpPinFlat(cmpPinFlat), .cmpIrq(cmpIrq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void modelWrite(int cpu, bit oth, int ofs, logic [31:0] d);
    int t;
    if (cpu >= NCPU) return;
    t = oth ? mOsel[cpu] : cpu;
    case (ofs)
      3: mMask[t] = mMask[t] & ~d[5:0];
      4: mMask[t] = mMask[t] | d[5:0];
      5: if (d[5:0] <= 6'd5) mRoute[t] = d & 32'h8000_003F;
      6: if (d < 32'(NCPU)) mOsel[t] = int'(d);
      8: begin mCmp[t] = d; mPend[t] = 1'b0; end
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] expRead(int cpu, bit oth, int ofs);
    int t;
    if (cpu >= NCPU) return 32'h0;
    t = oth ? mOsel[cpu] : cpu;
    case (ofs)
      1: return {30'b0, mPend[t], 1'b0};
      2: return {26'b0, mMask[t]};
      5: return mRoute[t];
      6: return 32'(mOsel[t]);
      7: return 32'(t);
      8: return mCmp[t];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(int cpu, bit oth, int ofs);
    if (cpu >= NCPU) return "R11";
    if (oth) return "R1";
    case (ofs)
      0: return "R5";
      1: return "R9";
      2: return "R3";
      5: return "R6";
      6: return "R2";
      7, 8, 9: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic doAcc(int cpu, bit oth, int ofs, bit wr, logic [31:0] d, logic [2:0] pulse = 3'b0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqOther = oth;
    reqOfs = 4'(ofs); reqCpu = 2'(cpu); reqWdata = d; timerExpire = pulse;
    @(negedge clk);
    lastRd = rspData; lastVld = rspValid;
    reqValid = 1'b0; reqWrite = 1'b0; timerExpire = 3'b0;
    if (wr) modelWrite(cpu, oth, ofs, d);
    for (int b = 0; b < NCPU; b++) if (pulse[b]) mPend[b] = 1'b1;
  endtask

  task automatic rdCheck(string tag, int cpu, bit oth, int ofs);
    doAcc(cpu, oth, ofs, 1'b0, 32'h0);
    check($sformatf("%s cpu%0d win%0d ofs%0d", tag, cpu, oth, ofs), lastRd, expRead(cpu, oth, ofs));
    check("R12 rspValid", {31'b0, lastVld}, {31'b0, cpu < NCPU});
  endtask

  task automatic sweep(string pre);
    for (int cpu = 0; cpu <= NCPU; cpu++)
      for (int oth = 0; oth < 2; oth++)
        for (int ofs = 0; ofs < 16; ofs++)
          rdCheck({pre, tagOf(cpu, oth[0], ofs)}, cpu, oth[0], ofs);
  endtask

  task automatic checkOuts();
    for (int b = 0; b < NCPU; b++) begin
      check("R10 cmpIrq", {31'b0, cmpIrq[b]}, {31'b0, mPend[b] & mMask[b][1] & mRoute[b][31]});
      check("R10 cmpValue", cmpValueFlat[b*32 +: 32], mCmp[b]);
      check("R10 cmpPin", {26'b0, cmpPinFlat[b*6 +: 6]}, {26'b0, mRoute[b][5:0]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqOther = 1'b0;
    reqOfs = '0; reqCpu = '0; reqWdata = '0; timerExpire = '0;
    for (int b = 0; b < NCPU; b++) begin
      mOsel[b] = 0; mMask[b] = 6'h32; mRoute[b] = 32'h8000_0000;
      mCmp[b] = 32'hFFFF_FFFF; mPend[b] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R7 rspValid after reset", {31'b0, rspValid}, 32'h0);
    checkOuts();
    sweep("R7/");

    // selector: every value including out-of-range ones
    for (int cpu = 0; cpu < NCPU; cpu++) begin
      for (int v = 0; v <= NCPU + 1; v++) begin
        doAcc(cpu, 1'b0, 6, 1'b1, 32'(v));
        rdCheck("R2", cpu, 1'b0, 6);
        rdCheck("R1 ident via remote", cpu, 1'b1, 7);
      end
      doAcc(cpu, 1'b0, 6, 1'b1, 32'h8000_0001);
      rdCheck("R2 wide value", cpu, 1'b0, 6);
    end
    for (int cpu = 0; cpu < NCPU; cpu++) doAcc(cpu, 1'b0, 6, 1'b1, 32'((cpu + 1) % NCPU));
    sweep("");

    // mask set/clear through the remote window, plus direct writes to the read-only mask
    for (int i = 0; i < 4; i++)
      for (int cpu = 0; cpu < NCPU; cpu++) begin
        doAcc(cpu, 1'b1, 4, 1'b1, 32'hFFFF_FFC0 | 32'((i * 13 + cpu * 7) & 63));
        doAcc(cpu, 1'b1, 3, 1'b1, 32'hFFFF_FFC0 | 32'((i * 29 + cpu * 5 + 3) & 63));
        doAcc(cpu, 1'b0, 2, 1'b1, 32'hFFFF_FFFF);
        rdCheck("R3", (cpu + 1) % NCPU, 1'b0, 2);
      end
    sweep("");

    // writes to control and read-only or unimplemented offsets
    for (int ofs = 0; ofs < 16; ofs++)
      if (ofs == 0 || ofs == 1 || ofs == 7 || ofs >= 9) doAcc(0, 1'b0, ofs, 1'b1, 32'hFFFF_FFFF);
    rdCheck("R5 ctrl after write", 0, 1'b0, 0);
    sweep("");

    // compare route: every pin code, both flag values, junk bits set
    for (int p = 0; p < 8; p++)
      for (int f = 0; f < 2; f++) begin
        doAcc(1, 1'b0, 5, 1'b1, (32'(f) << 31) | 32'h5A5A_5A00 | 32'(p));
        rdCheck("R6", 1, 1'b0, 5);
        doAcc(0, 1'b1, 5, 1'b1, (32'(1 - f) << 31) | 32'h0000_0F40 | 32'(7 - p));
        rdCheck("R6 remote", 1, 1'b0, 5);
        checkOuts();
      end

    // compare, pending and interrupt output
    for (int b = 0; b < NCPU; b++) begin
      doAcc(b, 1'b0, 4, 1'b1, 32'h2);
      doAcc(b, 1'b0, 5, 1'b1, 32'h8000_0000 | 32'(b + 2));
      doAcc(b, 1'b0, 8, 1'b1, 32'h1234_0000 + 32'(b * 32'h111));
      checkOuts();
      doAcc(b, 1'b0, 1, 1'b0, 32'h0, 3'(1 << b));
      rdCheck("R9 pending set", b, 1'b0, 1);
      checkOuts();
      doAcc(b, 1'b0, 3, 1'b1, 32'h2);
      checkOuts();
      doAcc(b, 1'b0, 4, 1'b1, 32'h2);
      doAcc(b, 1'b0, 5, 1'b1, 32'h0000_0001);
      checkOuts();
      doAcc(b, 1'b0, 5, 1'b1, 32'h8000_0001);
      checkOuts();
      doAcc(b, 1'b0, 8, 1'b1, 32'hCAFE_0000 | 32'(b));
      rdCheck("R9 pending cleared", b, 1'b0, 1);
      checkOuts();
      doAcc(b, 1'b0, 8, 1'b1, 32'h0BAD_0000 | 32'(b), 3'(1 << b));
      rdCheck("R9 expire wins", b, 1'b0, 1);
      checkOuts();
    end

    // requester index past the last processor
    doAcc(3, 1'b0, 8, 1'b1, 32'h0);
    doAcc(3, 1'b1, 4, 1'b1, 32'h3F);
    doAcc(3, 1'b0, 6, 1'b1, 32'h1);
    check("R11 no response", {31'b0, lastVld}, 32'h0);
    checkOuts();
    sweep("");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule